// File: doc/BRIEF.md
# Random Generator Host Command Front End

This block sits between a 32-bit register bus and a random number source with its startup health test. Software controls it by writing whole 32-bit command codes to one control offset. It follows progress by reading a one-byte status code at a second offset. Random words come back through the control offset. There are no flag bits. A command counts only when the written value equals a defined code exactly and the block is in the state where that command is legal. Every other write leaves the block unchanged.

Software brings the block up in a fixed order: reset, release, enable, zeroize, then it waits for the startup-test verdict and acknowledges it. After that, the block captures one word from the source and holds it until software reads it. Software then writes a read-acknowledge and a re-enable, and only then is the next word taken. A failed startup test locks the block until the next reset command. The entropy source and the health-test engine sit outside the block. They are seen only through a word input with a valid strobe and a done/pass pair.

Top module: `rng_host_ctrl`

## Requirements
- R1: A read with `rd_en_i` high returns its data on `rdata_o` one cycle later. Offset 0x4 returns `{24'h0, status}`. Offset 0x0 returns the held random word. Any other offset returns zero.
- R2: Writing 0x00000001 to offset 0x0 in any state gives status 0xAC from the next cycle. While the block stays in that held state, `ent_valid_i` captures nothing.
- R3: From the held state, 0x00000002 releases the block, 0x80000000 then enables it and 0x80000004 then starts the startup test. The start command raises `st_start_o` for exactly one cycle. Any of these commands written out of that order is ignored. Status reads 0x00 in all of these intermediate states.
- R4: While the test runs, `st_done_i` with `st_pass_i`=1 sets status 0x57, and with `st_pass_i`=0 it sets status 0xFA.
- R5: The 0xFA state is left only by a reset command. Every other command keeps it.
- R6: In the 0x57 state, 0x80000008 starts the word flow and `src_run_o` goes high. The first `ent_valid_i` then captures `ent_word_i` and sets status 0xED.
- R7: In the 0xED state, 0x8000000F drops status to 0x00 on the next cycle. No word is captured until 0x80000000 has put the flow back into running.
- R8: While status is 0xED, further `ent_valid_i` pulses leave the held word unchanged. This includes a pulse in the same cycle as the read-acknowledge.
- R9: A write whose value matches no command code, or a write to any offset other than 0x0, leaves the state unchanged.
- R10: The startup-test command clears the held word to zero.
- R11: Offset 0x0 reads zero whenever status is not 0xED, because reset, startup-test and read-acknowledge commands all clear the held word.
- R12: After `rst_ni` is released, status reads 0x00, the word reads zero, and `st_start_o` and `src_run_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data (command code) |
| rdata_o | output | 32 | Read data, one cycle after `rd_en_i` |
| ent_word_i | input | 32 | Random word from the source |
| ent_valid_i | input | 1 | Source word valid strobe |
| st_done_i | input | 1 | Startup test finished |
| st_pass_i | input | 1 | Startup test verdict, 1 = pass |
| st_start_o | output | 1 | One-cycle startup test start pulse |
| src_run_o | output | 1 | Source asked to produce a word |

## Verification
A host command and a source strobe can land on the same clock edge. The two key cases are a read-acknowledge arriving together with `ent_valid_i`, and a re-enable arriving together with `ent_valid_i`. Directed steps raise both signals in one cycle. The bench then expects the status to leave 0xED and the word to stay zero, and it expects the word from the enable cycle to be dropped. The random phase mixes commands, junk codes, source strobes and test verdicts, so that such collisions also occur at random. After every step, a bench state model predicts both the status and the word.

// File: rtl/rng_host_pkg.sv
package rng_host_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [WORD_W-1:0] CMD_RESET   = 32'h0000_0001;
  localparam logic [WORD_W-1:0] CMD_RELEASE = 32'h0000_0002;
  localparam logic [WORD_W-1:0] CMD_ENABLE  = 32'h8000_0000;
  localparam logic [WORD_W-1:0] CMD_ZEROIZE = 32'h8000_0004;
  localparam logic [WORD_W-1:0] CMD_ACKZ    = 32'h8000_0008;
  localparam logic [WORD_W-1:0] CMD_RDACK   = 32'h8000_000F;

  localparam logic [7:0] CODE_NONE   = 8'h00;
  localparam logic [7:0] CODE_RSTACK = 8'hAC;
  localparam logic [7:0] CODE_PASS   = 8'h57;
  localparam logic [7:0] CODE_FAIL   = 8'hFA;
  localparam logic [7:0] CODE_AVAIL  = 8'hED;

  typedef enum logic [2:0] {
    C_NONE, C_RESET, C_RELEASE, C_ENABLE, C_ZEROIZE, C_ACKZ, C_RDACK
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HELD, S_RELEASED, S_ENABLED, S_TESTING,
    S_PASSED, S_FAILED, S_RUN, S_AVAIL, S_PAUSED
  } state_e;

  function automatic logic [7:0] code_of(state_e s);
    case (s)
      S_HELD:   return CODE_RSTACK;
      S_PASSED: return CODE_PASS;
      S_FAILED: return CODE_FAIL;
      S_AVAIL:  return CODE_AVAIL;
      default:  return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rng_cmd_decode.sv
module rng_cmd_decode
  import rng_host_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CTRL_OFS = 0
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output cmd_e              cmd_o
);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_OFS);

  logic hit;
  assign hit = wr_en_i && (addr_i == CtrlAddr);

  always_comb begin
    cmd_o = C_NONE;
    if (hit) begin
      case (wdata_i)
        CMD_RESET:   cmd_o = C_RESET;
        CMD_RELEASE: cmd_o = C_RELEASE;
        CMD_ENABLE:  cmd_o = C_ENABLE;
        CMD_ZEROIZE: cmd_o = C_ZEROIZE;
        CMD_ACKZ:    cmd_o = C_ACKZ;
        CMD_RDACK:   cmd_o = C_RDACK;
        default:     cmd_o = C_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rng_host_fsm.sv
module rng_host_fsm
  import rng_host_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cmd_e   cmd_i,
  input  logic   ent_valid_i,
  input  logic   st_done_i,
  input  logic   st_pass_i,
  output state_e state_o,
  output logic   capture_o,
  output logic   clear_o,
  output logic   st_start_o,
  output logic   src_run_o,
  output logic [7:0] status_o
);
  state_e state_q, state_d;
  logic   start_q;
  logic   go_test;

  assign go_test = (state_q == S_ENABLED) && (cmd_i == C_ZEROIZE);

  always_comb begin
    state_d = state_q;
    if (cmd_i == C_RESET) begin
      state_d = S_HELD;
    end else begin
      case (state_q)
        S_HELD:     if (cmd_i == C_RELEASE) state_d = S_RELEASED;
        S_RELEASED: if (cmd_i == C_ENABLE)  state_d = S_ENABLED;
        S_ENABLED:  if (cmd_i == C_ZEROIZE) state_d = S_TESTING;
        S_TESTING:  if (st_done_i) state_d = st_pass_i ? S_PASSED : S_FAILED;
        S_PASSED:   if (cmd_i == C_ACKZ)    state_d = S_RUN;
        S_RUN:      if (ent_valid_i)        state_d = S_AVAIL;
        S_AVAIL:    if (cmd_i == C_RDACK)   state_d = S_PAUSED;
        S_PAUSED:   if (cmd_i == C_ENABLE)  state_d = S_RUN;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= go_test;
    end
  end

  // reset command wins over a same-cycle source strobe
  assign capture_o  = (state_q == S_RUN) && ent_valid_i && (cmd_i != C_RESET);
  assign clear_o    = (cmd_i == C_RESET) || go_test ||
                      ((state_q == S_AVAIL) && (cmd_i == C_RDACK));
  assign st_start_o = start_q;
  assign src_run_o  = (state_q == S_RUN);
  assign status_o   = code_of(state_q);
  assign state_o    = state_q;
endmodule

// File: rtl/rng_word_hold.sv
module rng_word_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        word_q <= '0;
    else if (clear_i)   word_q <= '0;
    else if (capture_i) word_q <= word_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/rng_bus_read.sv
module rng_bus_read #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned STAT_OFS = 4,
  parameter bit          RD_REG   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        status_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(STAT_OFS);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd_en_i) begin
      if (addr_i == StatAddr)      sel = DATA_W'(status_i);
      else if (addr_i == CtrlAddr) sel = word_i;
    end
  end

  generate
    if (RD_REG) begin : g_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdata_q <= '0;
        else         rdata_q <= sel;
      end
      assign rdata_o = rdata_q;
    end else begin : g_comb
      assign rdata_o = sel;
    end
  endgenerate
endmodule

// File: rtl/rng_host_ctrl.sv
module rng_host_ctrl
  import rng_host_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned STAT_OFS = 4,
  parameter bit          RD_REG   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [31:0]       ent_word_i,
  input  logic              ent_valid_i,
  input  logic              st_done_i,
  input  logic              st_pass_i,
  output logic              st_start_o,
  output logic              src_run_o
);
  cmd_e              cmd;
  state_e            state;
  logic              capture, clear;
  logic [7:0]        status;
  logic [WORD_W-1:0] word;

  rng_cmd_decode #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd)
  );

  rng_host_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .ent_valid_i (ent_valid_i),
    .st_done_i   (st_done_i),
    .st_pass_i   (st_pass_i),
    .state_o     (state),
    .capture_o   (capture),
    .clear_o     (clear),
    .st_start_o  (st_start_o),
    .src_run_o   (src_run_o),
    .status_o    (status)
  );

  rng_word_hold #(.DATA_W(WORD_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .clear_i   (clear),
    .word_i    (ent_word_i),
    .word_o    (word)
  );

  rng_bus_read #(
    .ADDR_W(ADDR_W), .DATA_W(WORD_W), .CTRL_OFS(CTRL_OFS),
    .STAT_OFS(STAT_OFS), .RD_REG(RD_REG)
  ) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .status_i (status),
    .word_i   (word),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/rng_host_ctrl_chk.sv
module rng_host_ctrl_chk
  import rng_host_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned STAT_OFS = 4,
  parameter bit          RD_REG   = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              ent_valid_i,
  input logic              st_done_i,
  input logic              st_start_o,
  input cmd_e              cmd,
  input state_e            state,
  input logic              capture,
  input logic [7:0]        status,
  input logic [31:0]       word
);
  generate
    if (RD_REG) begin : g_rd
      assert_stat_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i && addr_i == ADDR_W'(STAT_OFS) |=> rdata_o == {24'h0, $past(status)});
    end
  endgenerate

  assert_rst_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == C_RESET |=> status == CODE_RSTACK);

  assert_no_cap_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_HELD |-> !capture);

  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_start_o |=> !st_start_o);

  assert_fail_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_FAILED && cmd != C_RESET |=> state == S_FAILED);

  assert_rdack_leave_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_AVAIL && cmd == C_RDACK |=> status != CODE_AVAIL && word == 32'h0);

  assert_word_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_AVAIL && cmd != C_RESET && cmd != C_RDACK |=> $stable(word));

  assert_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == C_NONE && !ent_valid_i && !st_done_i |=> $stable(state));

  assert_zeroize_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == S_ENABLED && cmd == C_ZEROIZE |=> word == 32'h0);
endmodule

bind rng_host_ctrl rng_host_ctrl_chk #(
  .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .RD_REG(RD_REG)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .ent_valid_i (ent_valid_i),
  .st_done_i   (st_done_i),
  .st_start_o  (st_start_o),
  .cmd         (cmd),
  .state       (state),
  .capture     (capture),
  .status      (status),
  .word        (word)
);

// File: tb/rng_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module rng_host_ctrl_tb_top;
  import rng_host_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] ent_word = '0;
  logic        ent_valid = 1'b0, st_done = 1'b0, st_pass = 1'b0;
  logic        st_start, src_run;

  always #2 clk = ~clk;

  rng_host_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ent_word_i(ent_word), .ent_valid_i(ent_valid),
    .st_done_i(st_done), .st_pass_i(st_pass),
    .st_start_o(st_start), .src_run_o(src_run)
  );

  int     errors = 0, checks = 0;
  bit     finished = 1'b0;
  state_e m_st = S_IDLE;
  logic [31:0] m_word = '0;

  function automatic cmd_e m_dec(logic w, logic [3:0] a, logic [31:0] d);
    if (!w || a != 4'h0) return C_NONE;
    if (d == 32'h0000_0001) return C_RESET;
    if (d == 32'h0000_0002) return C_RELEASE;
    if (d == 32'h8000_0000) return C_ENABLE;
    if (d == 32'h8000_0004) return C_ZEROIZE;
    if (d == 32'h8000_0008) return C_ACKZ;
    if (d == 32'h8000_000F) return C_RDACK;
    return C_NONE;
  endfunction

  function automatic logic [7:0] m_code(state_e s);
    if (s == S_HELD)   return 8'hAC;
    if (s == S_PASSED) return 8'h57;
    if (s == S_FAILED) return 8'hFA;
    if (s == S_AVAIL)  return 8'hED;
    return 8'h00;
  endfunction

  function automatic state_e m_next(state_e s, cmd_e c, logic v, logic dn, logic ps);
    if (c == C_RESET) return S_HELD;
    if (s == S_HELD     && c == C_RELEASE) return S_RELEASED;
    if (s == S_RELEASED && c == C_ENABLE)  return S_ENABLED;
    if (s == S_ENABLED  && c == C_ZEROIZE) return S_TESTING;
    if (s == S_TESTING  && dn) return ps ? S_PASSED : S_FAILED;
    if (s == S_PASSED   && c == C_ACKZ)    return S_RUN;
    if (s == S_RUN      && v)              return S_AVAIL;
    if (s == S_AVAIL    && c == C_RDACK)   return S_PAUSED;
    if (s == S_PAUSED   && c == C_ENABLE)  return S_RUN;
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one bus/source cycle, model advanced alongside
  task automatic step(logic w, logic [3:0] a, logic [31:0] d, logic v,
                      logic [31:0] wd, logic dn, logic ps, string req);
    cmd_e c;
    logic exp_start;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    ent_valid = v; ent_word = wd; st_done = dn; st_pass = ps;
    c = m_dec(w, a, d);
    exp_start = (m_st == S_ENABLED) && (c == C_ZEROIZE);
    if (c == C_RESET || exp_start || (m_st == S_AVAIL && c == C_RDACK)) m_word = '0;
    else if (m_st == S_RUN && v) m_word = wd;
    m_st = m_next(m_st, c, v, dn, ps);
    @(negedge clk);
    wr_en = 0; ent_valid = 0; st_done = 0; addr = '0;
    chk({req, " st_start_o"}, {31'h0, st_start}, {31'h0, exp_start});
    chk({req, " src_run_o"}, {31'h0, src_run}, {31'h0, m_st == S_RUN});
  endtask

  task automatic cmd(logic [31:0] d, string req);
    step(1'b1, 4'h0, d, 1'b0, '0, 1'b0, 1'b0, req);
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] q);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
    q = rdata;
  endtask

  task automatic check_regs(string req);
    logic [31:0] q;
    rd(4'h4, q);
    chk({req, " status"}, q, {24'h0, m_code(m_st)});
    rd(4'h0, q);
    chk({req, " word"}, q, (m_st == S_AVAIL) ? m_word : 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 st_start_o", {31'h0, st_start}, 32'h0);
    chk("R12 src_run_o", {31'h0, src_run}, 32'h0);
    check_regs("R12");
    cmd(32'h8000_0000, "R3 early enable");
    check_regs("R3");
    cmd(32'h0000_0001, "R2");
    check_regs("R2");
    step(1'b0, 4'h0, '0, 1'b1, 32'h1111_2222, 1'b0, 1'b0, "R2 held valid");
    check_regs("R2 no capture");
    cmd(32'h8000_0001, "R9 junk");
    step(1'b1, 4'h4, 32'h0000_0002, 1'b0, '0, 1'b0, 1'b0, "R9 wrong offset");
    check_regs("R9");
    cmd(32'h8000_0004, "R3 zeroize early");
    cmd(32'h0000_0002, "R3 release");
    cmd(32'h8000_0004, "R3 zeroize early");
    cmd(32'h8000_0000, "R3 enable");
    check_regs("R3");
    cmd(32'h8000_0004, "R3 zeroize");
    check_regs("R10");
    rd(4'h8, q);
    chk("R1 other offset", q, 32'h0);
    step(1'b0, 4'h0, '0, 1'b0, '0, 1'b1, 1'b1, "R4 pass");
    check_regs("R4");
    cmd(32'h8000_0008, "R6 ackz");
    check_regs("R6");
    step(1'b0, 4'h0, '0, 1'b1, 32'hCAFE_0001, 1'b0, 1'b0, "R6 capture");
    check_regs("R6");
    step(1'b0, 4'h0, '0, 1'b1, 32'hCAFE_0002, 1'b0, 1'b0, "R8 extra");
    check_regs("R8");
    cmd(32'h8000_000F, "R7 rdack");
    check_regs("R7 R11");
    step(1'b0, 4'h0, '0, 1'b1, 32'hCAFE_0003, 1'b0, 1'b0, "R7 paused valid");
    check_regs("R7");
    cmd(32'h8000_0000, "R7 enable");
    step(1'b0, 4'h0, '0, 1'b1, 32'hCAFE_0004, 1'b0, 1'b0, "R7 capture");
    check_regs("R7");
    step(1'b1, 4'h0, 32'h8000_000F, 1'b1, 32'hCAFE_0005, 1'b0, 1'b0, "R8 same cycle");
    check_regs("R8 same cycle");
    step(1'b1, 4'h0, 32'h8000_0000, 1'b1, 32'hCAFE_0006, 1'b0, 1'b0, "R7 enable+valid");
    check_regs("R7 enable+valid");
    step(1'b0, 4'h0, '0, 1'b1, 32'hCAFE_0007, 1'b0, 1'b0, "R6 next");
    check_regs("R6 next");
    cmd(32'h0000_0001, "R2 reset");
    cmd(32'h0000_0002, "R3");
    cmd(32'h8000_0000, "R3");
    cmd(32'h8000_0004, "R3");
    step(1'b0, 4'h0, '0, 1'b0, '0, 1'b1, 1'b0, "R4 fail");
    check_regs("R4 fail");
    cmd(32'h8000_0008, "R5");
    cmd(32'h8000_0000, "R5");
    cmd(32'h0000_0002, "R5");
    cmd(32'h8000_000F, "R5");
    step(1'b0, 4'h0, '0, 1'b1, 32'h5555_AAAA, 1'b0, 1'b0, "R5 valid");
    check_regs("R5 sticky");
    cmd(32'h0000_0001, "R5 reset");
    check_regs("R5 cleared");

    for (int i = 0; i < 500; i++) begin
      logic [31:0] d;
      logic [3:0]  a;
      int sel;
      sel = $urandom_range(0, 11);
      a = 4'h0;
      case (sel)
        0:       d = ($urandom_range(0, 3) == 0) ? 32'h0000_0001 : 32'h8000_0000;
        1:       d = 32'h0000_0002;
        2, 3:    d = 32'h8000_0000;
        4:       d = 32'h8000_0004;
        5:       d = 32'h8000_0008;
        6, 7:    d = 32'h8000_000F;
        8:       d = $urandom();
        9:       begin d = 32'h8000_0000; a = 4'h4; end
        default: d = 32'h8000_0008 ^ (32'h1 << $urandom_range(0, 31));
      endcase
      step($urandom_range(0, 2) != 0, a, d, $urandom_range(0, 2) == 0, $urandom(),
           $urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0, "R9 random");
      check_regs("R6 R7 R8 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule